// File: doc/BRIEF.md
# Machine Status Word with Coprocessor Trap

This block holds the processor's 16-bit machine status word. Only the low four bits steer behaviour. Bit 0 enables protection. Bit 1 is the coprocessor monitor flag. Bit 2 is the coprocessor emulation flag. Bit 3 is the task-switched flag. The upper twelve bits are kept as written and read back unchanged, but they have no effect.

The block carries out three instructions from the decoded stream:

- **Load word:** writes the word, subject to a privilege check.
- **Store word:** allowed at every level; it neither faults nor changes anything.
- **Clear task-switched:** clears bit 3, subject to a privilege check.

A strobe from the task-switch hardware sets the task-switched flag.

For each decoded escape or wait instruction, the block decides whether the coprocessor-not-present exception (vector 7) must be raised. It also reports a general-protection fault (vector 13) when a privileged operation lacks privilege. Faults appear as one-cycle strobes in the cycle after the instruction is presented, with the vector number alongside. The dispatch logic around the block consumes these strobes.

Top module: `msw_unit`

## Requirements
- R1: While `rstN` is low, and after it is released, `statusWord` reads 0x0000 and `gpFault`, `cpFault` and `excVector` read zero.
- R2: A load (`opClass`=1 with `opValid` high) issued while `protMode` is low, or at `cpl`=0, writes all 16 bits of `loadData` into `statusWord` at the next clock edge. Bit 0 is the OR of its old value and the loaded bit.
- R3: A load issued with `protMode` high and `cpl` not 0 leaves `statusWord` unchanged. In the next cycle it pulses `gpFault` with `excVector`=13.
- R4: Once bit 0 of `statusWord` is 1, only reset returns it to 0.
- R5: A store (`opClass`=2) at any `cpl` raises no fault and leaves `statusWord` unchanged.
- R6: A high `taskSwitch` sets bit 3 at the next edge. This takes precedence over a clear or a load presented in the same cycle.
- R7: A clear-task-switched (`opClass`=3) at `cpl`=0 clears bit 3 only. At any other `cpl` it leaves the word unchanged and pulses `gpFault` with `excVector`=13.
- R8: An escape (`opClass`=4) pulses `cpFault` with `excVector`=7 in the next cycle exactly when bit 2 or bit 3 is set.
- R9: A wait (`opClass`=5) pulses `cpFault` with `excVector`=7 exactly when bit 1 and bit 3 are both set. Bit 2 plays no part.
- R10: Bits 15 to 4 have no influence on any trap. Other classes (`opClass`=0), and any class while `opValid` is low, change nothing and raise nothing.
- R11: Fault strobes last one cycle per instruction, `gpFault` and `cpFault` are never high together, and `excVector` is 0 when neither is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | A decoded instruction is present this cycle |
| opClass | input | 3 | Instruction class: 0 other, 1 load, 2 store, 3 clear-TS, 4 escape, 5 wait |
| cpl | input | 2 | Current privilege level |
| protMode | input | 1 | High when executing in protected mode |
| taskSwitch | input | 1 | Hardware task-switch strobe |
| loadData | input | 16 | Operand of the load instruction |
| statusWord | output | 16 | Current word, also the store result |
| gpFault | output | 1 | General-protection fault strobe |
| cpFault | output | 1 | Coprocessor-not-present fault strobe |
| excVector | output | 8 | Vector of the strobe raised, else 0 |

## Verification
A wrong internal bit shows up directly on `statusWord` one edge after the operation that produced it. A flag that is stuck or wrongly cleared shows up later, on the first escape or wait instruction that consults it, as a missing or spurious `cpFault`.

The stimulus therefore follows each change of a flag with escape and wait probes in the next few cycles. It also revisits the protection bit after a load of zero and after a reset.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int WordW = 16;
  localparam int VecW = 8;
  localparam int PeBit = 0;
  localparam int MpBit = 1;
  localparam int EmBit = 2;
  localparam int TsBit = 3;
  localparam logic [VecW-1:0] CpVec = 8'd7;
  localparam logic [VecW-1:0] GpVec = 8'd13;

  typedef enum logic [2:0] {
    OpOther = 3'd0,
    OpLoad  = 3'd1,
    OpStore = 3'd2,
    OpClrTs = 3'd3,
    OpEsc   = 3'd4,
    OpWait  = 3'd5
  } opClassT;

  typedef struct packed {
    logic loadEn;
    logic clrTs;
    logic setTs;
  } wordStrobeT;
endpackage

// File: rtl/msw_ctrl.sv
module msw_ctrl
  import msw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opClass,
  input  logic [1:0]       cpl,
  input  logic             protMode,
  input  logic             taskSwitch,
  input  logic             mpFlag,
  input  logic             emFlag,
  input  logic             tsFlag,
  output wordStrobeT       strobes,
  output logic             gpFault,
  output logic             cpFault,
  output logic [VecW-1:0]  excVector
);
  logic isLoad, isClr, isEsc, isWait;
  logic loadPriv, clrPriv, gpNext, cpNext;

  always_comb begin
    isLoad   = opValid && (opClass == OpLoad);
    isClr    = opValid && (opClass == OpClrTs);
    isEsc    = opValid && (opClass == OpEsc);
    isWait   = opValid && (opClass == OpWait);
    loadPriv = !protMode || (cpl == 2'd0);
    clrPriv  = (cpl == 2'd0);
    strobes.loadEn = isLoad && loadPriv;
    strobes.clrTs  = isClr && clrPriv;
    strobes.setTs  = taskSwitch;
    gpNext = (isLoad && !loadPriv) || (isClr && !clrPriv);
    cpNext = (isEsc && (emFlag || tsFlag)) || (isWait && mpFlag && tsFlag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpFault   <= 1'b0;
      cpFault   <= 1'b0;
      excVector <= '0;
    end else begin
      gpFault   <= gpNext;
      cpFault   <= cpNext;
      excVector <= gpNext ? GpVec : (cpNext ? CpVec : '0);
    end
  end

  // R11
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gpFault && cpFault));
  // R8
  esc_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OpEsc && (emFlag || tsFlag)) |=> (cpFault && excVector == CpVec));
  // R9
  wait_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == OpWait && !(mpFlag && tsFlag)) |=> !cpFault);
  // R11
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gpFault && !cpFault) |-> (excVector == '0));
endmodule

// File: rtl/msw_data.sv
module msw_data
  import msw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  wordStrobeT       strobes,
  input  logic [WordW-1:0] loadData,
  output logic [WordW-1:0] word
);
  logic [WordW-1:0] nextWord;

  always_comb begin
    nextWord = word;
    if (strobes.loadEn) begin
      nextWord = loadData;
      nextWord[PeBit] = loadData[PeBit] | word[PeBit];
    end
    if (strobes.clrTs) nextWord[TsBit] = 1'b0;
    if (strobes.setTs) nextWord[TsBit] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) word <= '0;
    else       word <= nextWord;
  end

  // R4
  pe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    word[PeBit] |=> word[PeBit]);
  // R6
  ts_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setTs |=> word[TsBit]);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadEn && !strobes.clrTs && !strobes.setTs) |=> $stable(word));
endmodule

// File: rtl/msw_unit.sv
module msw_unit
  import msw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [2:0]  opClass,
  input  logic [1:0]  cpl,
  input  logic        protMode,
  input  logic        taskSwitch,
  input  logic [15:0] loadData,
  output logic [15:0] statusWord,
  output logic        gpFault,
  output logic        cpFault,
  output logic [7:0]  excVector
);
  wordStrobeT strobes;
  logic [WordW-1:0] word;

  msw_ctrl ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .cpl(cpl), .protMode(protMode), .taskSwitch(taskSwitch),
    .mpFlag(word[MpBit]), .emFlag(word[EmBit]), .tsFlag(word[TsBit]),
    .strobes(strobes), .gpFault(gpFault), .cpFault(cpFault),
    .excVector(excVector)
  );

  msw_data data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadData(loadData), .word(word)
  );

  assign statusWord = word;
endmodule

// File: tb/msw_unit_test.sv
module msw_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opClass = 3'd0;
  logic [1:0] cpl = 2'd0;
  logic protMode = 1'b0;
  logic taskSwitch = 1'b0;
  logic [15:0] loadData = 16'h0;
  logic [15:0] statusWord;
  logic gpFault, cpFault;
  logic [7:0] excVector;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] w;
    logic gp;
    logic cp;
    logic [7:0] v;
    string tag;
  } expT;
  expT q[$];
  logic [15:0] model = 16'h0;

  always #4 clk = ~clk;

  msw_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .cpl(cpl), .protMode(protMode), .taskSwitch(taskSwitch),
    .loadData(loadData), .statusWord(statusWord), .gpFault(gpFault),
    .cpFault(cpFault), .excVector(excVector)
  );

  task automatic compare(input expT e);
    total++;
    if (statusWord !== e.w || gpFault !== e.gp || cpFault !== e.cp || excVector !== e.v) begin
      bad++;
      $display("FAIL %s: got w=%h gp=%b cp=%b v=%0d, want w=%h gp=%b cp=%b v=%0d",
               e.tag, statusWord, gpFault, cpFault, excVector, e.w, e.gp, e.cp, e.v);
    end
  endtask

  // driver: present one instruction and predict the result
  task automatic drive(input bit vld, input logic [2:0] cls, input logic [1:0] lvl,
                       input bit pm, input bit tsw, input logic [15:0] d, input string tag);
    expT e;
    bit privLoad, gp, cp;
    @(negedge clk);
    opValid = vld; opClass = cls; cpl = lvl; protMode = pm;
    taskSwitch = tsw; loadData = d;
    privLoad = !pm || lvl == 2'd0;
    gp = 0; cp = 0;
    if (vld && cls == 3'd1) begin
      if (privLoad) model = {d[15:1], d[0] | model[0]};
      else gp = 1;
    end
    if (vld && cls == 3'd3) begin
      if (lvl == 2'd0) model[3] = 1'b0;
      else gp = 1;
    end
    if (vld && cls == 3'd4) cp = model[2] | model[3];
    if (vld && cls == 3'd5) cp = model[1] & model[3];
    if (tsw) model[3] = 1'b1;
    e.w = model; e.gp = gp; e.cp = cp;
    e.v = gp ? 8'd13 : (cp ? 8'd7 : 8'd0);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic idle();
    @(negedge clk);
    opValid = 0; taskSwitch = 0; opClass = 3'd0;
    @(negedge clk);
  endtask

  task automatic resetCheck(input string tag);
    expT e;
    e.w = 16'h0; e.gp = 0; e.cp = 0; e.v = 8'd0; e.tag = tag;
    compare(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    resetCheck("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    resetCheck("R1 after release");

    drive(1, 3'd1, 2'd3, 0, 0, 16'h0002, "R2 real-mode load");
    drive(1, 3'd4, 2'd3, 0, 0, 16'h0,    "R8 escape no trap");
    drive(1, 3'd0, 2'd3, 0, 1, 16'h0,    "R6 task switch");
    drive(1, 3'd5, 2'd3, 0, 0, 16'h0,    "R9 wait with MP and TS");
    drive(1, 3'd4, 2'd3, 0, 0, 16'h0,    "R8 escape with TS");
    drive(1, 3'd1, 2'd0, 0, 0, 16'hF005, "R2 upper bits stored");
    drive(1, 3'd1, 2'd3, 1, 0, 16'h0000, "R3 unprivileged load");
    drive(1, 3'd3, 2'd3, 1, 0, 16'h0,    "R7 unprivileged clear");
    drive(1, 3'd2, 2'd3, 1, 0, 16'h0,    "R5 store at cpl 3");
    drive(1, 3'd4, 2'd3, 1, 0, 16'h0,    "R8 escape with EM");
    drive(1, 3'd5, 2'd3, 1, 0, 16'h0,    "R9 wait ignores EM");
    drive(1, 3'd1, 2'd0, 1, 0, 16'h0000, "R4 load zero keeps PE");
    drive(1, 3'd3, 2'd0, 1, 1, 16'h0,    "R6 switch beats clear");
    drive(1, 3'd3, 2'd0, 1, 0, 16'h0,    "R7 privileged clear");
    drive(1, 3'd5, 2'd0, 1, 0, 16'h0,    "R9 wait TS clear");
    drive(1, 3'd1, 2'd0, 1, 0, 16'h0002, "R2 set MP");
    drive(1, 3'd5, 2'd0, 1, 0, 16'h0,    "R9 wait MP no TS");
    drive(1, 3'd1, 2'd0, 1, 1, 16'h0002, "R6 switch beats load");
    drive(1, 3'd5, 2'd0, 1, 0, 16'h0,    "R9 wait traps");
    drive(0, 3'd1, 2'd0, 1, 0, 16'hFFFF, "R10 invalid load ignored");
    drive(1, 3'd1, 2'd0, 1, 0, 16'hFFF0, "R2 upper bits only");
    drive(1, 3'd4, 2'd0, 1, 0, 16'h0,    "R10 upper bits no trap");
    drive(1, 3'd5, 2'd0, 1, 0, 16'h0,    "R10 wait upper bits");
    drive(1, 3'd0, 2'd3, 1, 0, 16'h0,    "R10 other class");
    drive(1, 3'd2, 2'd0, 1, 0, 16'h0,    "R5 store at cpl 0");
    drive(0, 3'd0, 2'd0, 1, 0, 16'h0,    "R11 strobe drops");
    idle();

    @(negedge clk);
    rstN = 1'b0;
    model = 16'h0;
    #1;
    resetCheck("R1 reset clears PE");
    @(negedge clk);
    rstN = 1'b1;
    drive(1, 3'd4, 2'd0, 0, 0, 16'h0,    "R1 escape after reset");
    drive(1, 3'd1, 2'd3, 0, 0, 16'h0004, "R2 real mode any cpl");
    drive(1, 3'd5, 2'd3, 0, 0, 16'h0,    "R9 wait EM only");
    drive(0, 3'd0, 2'd0, 0, 0, 16'h0,    "R11 idle");
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule